// File: doc/BRIEF.md
# Processor Stop-Clock Throttle Sequencer

This block throttles a processor by driving a stop-clock pin. When a throttle request arrives it first freezes a copy of the processor interface signal vector, then raises stop-clock a few fast-clock cycles later. The frozen copy is presented to the processor for the whole stop window, so its pins cannot move while its clock is gated.

A break event pulse ends the window. Stop-clock drops a fixed number of cycles after the break. The frozen interface vector is let go a further fixed number of cycles after that, and the output then follows the live vector again. Each delay is a cycle count set by a parameter. The defaults (2, 10 and 40 cycles of a roughly 15 ns clock) land inside the allowed windows: 0 to 4 cycles of latch lead, 30 to 3120 ns from break to deassertion, and 240 to 1880 ns from deassertion to release.

The interface vector is a set of level pins sampled every cycle. It is not a transaction stream, so there is no valid/ready handshake and no back-pressure. The request and break inputs are plain control pins, sampled on each rising clock edge.

Top module: `stop_clk_ctrl`

## Requirements
- R1: While reset is asserted, `stop_clk` is 0 and `if_held` equals `if_live`.
- R2: While idle, `if_held` follows `if_live` in the same cycle. A `break_evt` received while idle has no effect.
- R3: When `throttle_req` is 1 at a clock edge while idle, `if_live` is captured at that edge. `stop_clk` rises exactly PRE_CYC (default 2) edges later.
- R4: From the capture edge until release, `if_held` equals the captured value, whatever `if_live` does.
- R5: When `break_evt` is 1 at an edge while stop-clock is asserted, `stop_clk` falls exactly DEASSERT_CYC (default 10) edges later.
- R6: `if_held` returns to following `if_live` exactly RELEASE_CYC (default 40) edges after the edge at which `stop_clk` fell.
- R7: `throttle_req` and `break_evt` have no effect during the release countdown. A request is accepted again at the first edge after release, including one that is held high throughout.
- R8: A `break_evt` that arrives before `stop_clk` has risen is ignored. `stop_clk` still rises and stays high until a later break.
- R9: Without a break event, `stop_clk` stays high indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| throttle_req | input | 1 | Level request to start a stop window |
| break_evt | input | 1 | Pulse that ends an active stop window |
| if_live | input | W | Live processor interface signal vector |
| stop_clk | output | 1 | Stop-clock to the processor, active high |
| if_held | output | W | Interface vector presented to the processor |

## Verification
Each result lands at a fixed number of edges after its stimulus. The capture is visible after the first edge. Stop-clock rises PRE_CYC edges after capture and falls DEASSERT_CYC edges after the break is sampled. Release follows RELEASE_CYC edges after the fall. When the bench drives a stimulus, it records the exact cycle index at which each result is due, both on and one cycle before every boundary. It compares the outputs only at the falling edge of that cycle, so an early or late transition by even one edge is caught.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,    // pass-through, no stop window
    ST_ARM,     // vector frozen, stop-clock not yet raised
    ST_STOP,    // stop-clock asserted, waiting for a break
    ST_DRAIN,   // break seen, counting to stop-clock deassertion
    ST_UNHOLD   // stop-clock low, counting to vector release
  } sc_state_e;

  function automatic int sc_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sc_cycle_timer.sv
module sc_cycle_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  // expired goes high len-1 edges after the start edge, i.e. the owner
  // acts on it exactly len edges after issuing start
  assign expired = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= len - CW'(1);
      run_q <= 1'b1;
    end else if (expired) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/sc_sequencer.sv
module sc_sequencer
  import sc_pkg::*;
#(
  parameter int PRE_CYC      = 2,
  parameter int DEASSERT_CYC = 10,
  parameter int RELEASE_CYC  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic throttle_req,
  input  logic break_evt,
  output logic capture,
  output logic hold_en,
  output logic stop_clk
);
  localparam int MAXC = sc_max3(PRE_CYC, DEASSERT_CYC, RELEASE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  sc_state_e     state_q, state_d;
  logic          tmr_start;
  logic [CW-1:0] tmr_len;
  logic          tmr_done;

  sc_cycle_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .len     (tmr_len),
    .expired (tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    tmr_len   = '0;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (throttle_req) begin
          capture   = 1'b1;
          tmr_start = 1'b1;
          tmr_len   = CW'(PRE_CYC);
          state_d   = ST_ARM;
        end
      end
      ST_ARM: begin
        if (tmr_done) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (break_evt) begin
          tmr_start = 1'b1;
          tmr_len   = CW'(DEASSERT_CYC);
          state_d   = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (tmr_done) begin
          tmr_start = 1'b1;
          tmr_len   = CW'(RELEASE_CYC);
          state_d   = ST_UNHOLD;
        end
      end
      ST_UNHOLD: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign hold_en  = (state_q != ST_IDLE);
  assign stop_clk = (state_q == ST_STOP) || (state_q == ST_DRAIN);
endmodule

// File: rtl/sc_if_hold.sv
module sc_if_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         hold_en,
  input  logic [W-1:0] if_live,
  output logic [W-1:0] if_held
);
  logic [W-1:0] snap_q;

  for (genvar g = 0; g < W; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q[g] <= 1'b0;
      else if (capture) snap_q[g] <= if_live[g];
    end
    assign if_held[g] = hold_en ? snap_q[g] : if_live[g];
  end
endmodule

// File: rtl/stop_clk_ctrl.sv
module stop_clk_ctrl #(
  parameter int W            = 8,
  parameter int PRE_CYC      = 2,
  parameter int DEASSERT_CYC = 10,
  parameter int RELEASE_CYC  = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         throttle_req,
  input  logic         break_evt,
  input  logic [W-1:0] if_live,
  output logic         stop_clk,
  output logic [W-1:0] if_held
);
  logic capture;
  logic hold_en;

  sc_sequencer #(
    .PRE_CYC      (PRE_CYC),
    .DEASSERT_CYC (DEASSERT_CYC),
    .RELEASE_CYC  (RELEASE_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .throttle_req (throttle_req),
    .break_evt    (break_evt),
    .capture      (capture),
    .hold_en      (hold_en),
    .stop_clk     (stop_clk)
  );

  sc_if_hold #(.W(W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .hold_en (hold_en),
    .if_live (if_live),
    .if_held (if_held)
  );
endmodule

// File: rtl/stop_clk_ctrl_chk.sv
module stop_clk_ctrl_chk #(
  parameter int W           = 8,
  parameter int PRE_CYC     = 2,
  parameter int RELEASE_CYC = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stop_clk,
  input logic         hold_en,
  input logic [W-1:0] if_held
);
  localparam int LIM = (PRE_CYC > RELEASE_CYC ? PRE_CYC : RELEASE_CYC) + 1;
  localparam int KW  = $clog2(LIM + 1);

  logic [KW-1:0] arm_cnt;   // cycles frozen before stop-clock
  logic [KW-1:0] rel_cnt;   // cycles frozen after stop-clock dropped

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= '0;
      rel_cnt <= '0;
    end else begin
      if (!hold_en)                  arm_cnt <= '0;
      else if (arm_cnt < KW'(LIM))   arm_cnt <= arm_cnt + KW'(1);
      if (stop_clk || !hold_en)      rel_cnt <= '0;
      else if (rel_cnt < KW'(LIM))   rel_cnt <= rel_cnt + KW'(1);
    end
  end

  // R3: stop-clock is only ever high while the vector is frozen
  p_stop_needs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clk |-> hold_en);

  // R3: stop-clock rises exactly PRE_CYC edges after the capture
  p_arm_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_clk) |-> (arm_cnt == KW'(PRE_CYC)));

  // R4: frozen output never moves while the hold persists
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && $past(hold_en)) |-> $stable(if_held));

  // R6: release comes exactly RELEASE_CYC edges after stop-clock fell
  p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_en) |-> (rel_cnt == KW'(RELEASE_CYC)));

  // R6: stop-clock drops while the vector is still frozen
  p_fall_inside_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_clk) |-> hold_en);
endmodule

bind stop_clk_ctrl stop_clk_ctrl_chk #(
  .W           (W),
  .PRE_CYC     (PRE_CYC),
  .RELEASE_CYC (RELEASE_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_clk (stop_clk),
  .hold_en  (hold_en),
  .if_held  (if_held)
);

// File: tb/test_stop_clk_ctrl.sv
module test_stop_clk_ctrl;
  localparam int W    = 8;
  localparam int PRE  = 2;
  localparam int DEAS = 10;
  localparam int REL  = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         throttle_req = 1'b0;
  logic         break_evt = 1'b0;
  logic [W-1:0] if_live = '0;
  logic         stop_clk;
  logic [W-1:0] if_held;

  stop_clk_ctrl #(.W(W), .PRE_CYC(PRE), .DEASSERT_CYC(DEAS), .RELEASE_CYC(REL)) i_stop_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .throttle_req(throttle_req), .break_evt(break_evt),
    .if_live(if_live), .stop_clk(stop_clk), .if_held(if_held)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scoreboard of expected output samples, ordered by cycle index
  int           q_cyc[$];
  logic         q_stop[$];
  logic [W-1:0] q_held[$];
  string        q_tag[$];

  task automatic expect_at(input int c, input logic s, input logic [W-1:0] h, input string tag);
    q_cyc.push_back(c); q_stop.push_back(s); q_held.push_back(h); q_tag.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) step();
  endtask

  // monitor: compares at the falling edge of the due cycle
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      checks++;
      if (q_cyc[0] < cyc) begin
        errors++;
        $display("FAIL %s: slot %0d missed (actual cycle %0d, expected cycle %0d)",
                 q_tag[0], q_cyc[0], cyc, q_cyc[0]);
      end else if (stop_clk !== q_stop[0] || if_held !== q_held[0]) begin
        errors++;
        $display("FAIL %s @%0d: actual stop=%0b held=%h expected stop=%0b held=%h",
                 q_tag[0], cyc, stop_clk, if_held, q_stop[0], q_held[0]);
      end
      void'(q_cyc.pop_front()); void'(q_stop.pop_front());
      void'(q_held.pop_front()); void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, b;
    if_live = 8'h6E;
    repeat (3) step();
    expect_at(cyc, 1'b0, 8'h6E, "R1 reset outputs");
    step();
    rst_n = 1'b1;

    // R2: idle pass-through and break ignored in idle
    step();
    if_live = 8'h11;
    expect_at(cyc, 1'b0, 8'h11, "R2 idle pass-through");
    break_evt = 1'b1; step(); break_evt = 1'b0;
    c = cyc;
    expect_at(c + 3, 1'b0, 8'h11, "R2 break in idle ignored");
    wait_until(c + 5);

    // R3/R4/R9: throttle, capture, stop window held
    c = cyc;
    if_live = 8'h3C; throttle_req = 1'b1;
    expect_at(c + 1, 1'b0, 8'h3C, "R3 captured, stop still low");
    expect_at(c + 2, 1'b0, 8'h3C, "R3 stop low one edge before");
    expect_at(c + 3, 1'b1, 8'h3C, "R3 stop rises after lead");
    step();
    throttle_req = 1'b0; if_live = 8'hA5;
    expect_at(c + 8, 1'b1, 8'h3C, "R4 held despite live change");
    wait_until(c + 20);
    if_live = 8'h0F;
    expect_at(c + 25, 1'b1, 8'h3C, "R9 stop stays without break");
    wait_until(c + 30);

    // R5/R6/R7: break, deassert, release, ignored inputs while releasing
    b = cyc;
    break_evt = 1'b1; step(); break_evt = 1'b0;
    expect_at(b + 10, 1'b1, 8'h3C, "R5 stop high one edge before");
    expect_at(b + 11, 1'b0, 8'h3C, "R5 stop falls after break");
    expect_at(b + 30, 1'b0, 8'h3C, "R7 break during release ignored");
    expect_at(b + 50, 1'b0, 8'h3C, "R6 still held one edge before");
    expect_at(b + 51, 1'b0, 8'h5A, "R6 released to live");
    expect_at(b + 56, 1'b0, 8'h5A, "R7 throttle during release ignored");
    wait_until(b + 20);
    break_evt = 1'b1; step(); break_evt = 1'b0;
    wait_until(b + 25);
    throttle_req = 1'b1; step(); throttle_req = 1'b0;
    wait_until(b + 40);
    if_live = 8'h5A;
    wait_until(b + 58);

    // R8: break before stop rises is ignored; throttle held throughout
    c = cyc;
    if_live = 8'hC3; throttle_req = 1'b1;
    step();
    break_evt = 1'b1; step(); break_evt = 1'b0;
    if_live = 8'h99;
    expect_at(c + 3, 1'b1, 8'hC3, "R8 stop rises despite early break");
    expect_at(c + 30, 1'b1, 8'hC3, "R8 stop persists after early break");
    wait_until(c + 31);
    b = cyc;
    break_evt = 1'b1; step(); break_evt = 1'b0;
    if_live = 8'h77;
    expect_at(b + 11, 1'b0, 8'hC3, "R5 second window falls");
    expect_at(b + 50, 1'b0, 8'hC3, "R6 second window still held");
    expect_at(b + 51, 1'b0, 8'h77, "R6 second window released");
    expect_at(b + 53, 1'b0, 8'h77, "R7 held request recaptured");
    expect_at(b + 54, 1'b1, 8'h77, "R7 new window stop rises");
    wait_until(b + 52);
    throttle_req = 1'b0; if_live = 8'h44;
    wait_until(b + 60);

    // close the last window
    b = cyc;
    break_evt = 1'b1; step(); break_evt = 1'b0;
    expect_at(b + 11, 1'b0, 8'h77, "R5 third window falls");
    expect_at(b + 51, 1'b0, 8'h44, "R6 third window released");
    wait_until(b + 55);

    while (q_cyc.size() > 0) step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule